// File: doc/BRIEF.md
# Timer compare pulse unit

This block watches a free-running 31-bit time counter and produces output events from four independent compare channels. Each channel has a control/status register and a compare-value register on a simple memory-mapped register bus. When the counter steps onto a channel's armed compare value, the channel raises its event flag and drives its output pin. Depending on the mode field, the pin either carries a one-clock high pulse or changes state. The flags can be combined into one interrupt line.

The compare value is held in two stages. Software loads a first value while the channel is idle, enables the mode, and then queues a second value. Each event promotes the queued value to active, which frees the queue for the value after that. Refilling the queue once per event gives a steady pulse train, such as a once-per-second strobe. A global compare enable input gates every channel. The counter itself is not part of the block and arrives on an input.

Top module: `tcmp_unit`

## Requirements
- R1: After reset all pins, match pulses and the interrupt are low, and every register reads zero.
- R2: The status register is at 0x604 and shows the flag of channel n in bit n. Channel n's control/status register is at 0x608+8n: bit 0 request enable, bits 5:2 mode, bit 6 interrupt enable, bit 7 flag. Its compare register, at 0x60C+8n, reads back the active compare value. Written fields read back.
- R3: A compare write to a channel with no armed value is accepted only while its mode is 0. Otherwise it is ignored, and the compare register keeps its previous value.
- R4: A match occurs only when an armed channel sees the counter step onto its active value. Compare values are masked to 31 bits. A counter that holds on the value does not match. A value already passed waits for the counter to wrap back around to it.
- R5: In mode 0xF the pin is high for exactly the one cycle after the clock edge that samples the matching counter value.
- R6: In mode 0x5 the pin changes state at the clock edge that samples the matching counter value.
- R7: A match sets the channel flag. Writing 1 to bit 7 clears it, and writing 0 leaves it set. A match in the same cycle as a clear leaves the flag set.
- R8: A compare write to an armed channel goes to the queued stage, replacing any queued value. At each match the queued value becomes active. With nothing queued, the channel disarms after the match.
- R9: The interrupt output is high exactly when some channel has both its flag and its interrupt enable set.
- R10: Writing mode 0 disarms the channel, drops both compare stages and drives its pin low.
- R11: While the global compare enable is low, no channel matches.
- R12: The match output of a channel pulses high for one cycle at each event, aligned with the flag update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 31 | Free-running time counter value |
| gen_en_i | input | 1 | Global compare enable |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| pin_o | output | 4 | Channel output pins |
| match_o | output | 4 | One-cycle match pulse per channel |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest behaviour to reach from the ports is the wrap of the 31-bit counter onto a value that was already passed. Letting the counter run would take billions of cycles. The bench drives the counter input itself and parks it a few counts below the wrap, so the active value is reached only after the roll-over. It also holds the counter still on an armed value to show that a hold is not a step. Queued values are refilled between events, with a replacement written before the first event, so the scoreboard must see the exact sequence of active values.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

    // mode field encodings
    localparam logic [3:0] MODE_OFF    = 4'h0;
    localparam logic [3:0] MODE_TOGGLE = 4'h5;
    localparam logic [3:0] MODE_PULSE  = 4'hF;

    // control/status bit positions
    localparam int CSR_REQ_BIT  = 0;
    localparam int CSR_MODE_LSB = 2;
    localparam int CSR_IE_BIT   = 6;
    localparam int CSR_FLAG_BIT = 7;
    localparam int CSR_W        = 8;

endpackage

// File: rtl/tcmp_regdec.sv
module tcmp_regdec #(
    parameter int NCH       = 4,
    parameter int AW        = 12,
    parameter int STAT_ADDR = 'h604,
    parameter int CH_BASE   = 'h608,
    parameter int CH_STRIDE = 8
) (
    input  logic [AW-1:0]  addr_i,
    output logic           stat_hit_o,
    output logic [NCH-1:0] csr_hit_o,
    output logic [NCH-1:0] cmp_hit_o
);

    localparam logic [AW-1:0] STAT_A = AW'(STAT_ADDR);

    assign stat_hit_o = (addr_i == STAT_A);

    for (genvar i = 0; i < NCH; i++) begin : g_dec
        localparam logic [AW-1:0] CSR_A = AW'(CH_BASE + i * CH_STRIDE);
        localparam logic [AW-1:0] CMP_A = AW'(CH_BASE + i * CH_STRIDE + 4);
        assign csr_hit_o[i] = (addr_i == CSR_A);
        assign cmp_hit_o[i] = (addr_i == CMP_A);
    end

endmodule

// File: rtl/tcmp_chan.sv
module tcmp_chan
    import tcmp_pkg::*;
#(
    parameter int CW = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     cnt_i,
    input  logic              step_i,
    input  logic              gen_en_i,
    input  logic              csr_we_i,
    input  logic              cmp_we_i,
    input  logic [CW-1:0]     wdata_i,
    output logic [CSR_W-1:0]  csr_o,
    output logic [CW-1:0]     cmp_o,
    output logic              flag_o,
    output logic              irq_o,
    output logic              pin_o,
    output logic              match_o
);

    typedef struct packed {
        logic [CW-1:0] cmp_act;
        logic [CW-1:0] cmp_nxt;
        logic          act_v;
        logic          nxt_v;
        logic          req_en;
        logic [3:0]    mode;
        logic          ie;
        logic          flag;
        logic          pin;
        logic          match;
    } chan_st_t;

    chan_st_t st_d, st_q;

    logic       mode_live;
    logic       hit;
    logic [3:0] wr_mode;

    assign wr_mode   = wdata_i[CSR_MODE_LSB +: 4];
    assign mode_live = (st_q.mode == MODE_TOGGLE) || (st_q.mode == MODE_PULSE);
    assign hit       = st_q.act_v && mode_live && gen_en_i && step_i
                       && (cnt_i == st_q.cmp_act);

    always_comb begin
        st_d       = st_q;
        st_d.match = 1'b0;
        if (st_q.mode == MODE_PULSE) begin
            st_d.pin = 1'b0;
        end

        // event handling
        if (hit) begin
            st_d.match = 1'b1;
            st_d.flag  = 1'b1;
            if (st_q.mode == MODE_PULSE) begin
                st_d.pin = 1'b1;
            end else begin
                st_d.pin = ~st_q.pin;
            end
            if (st_q.nxt_v) begin
                st_d.cmp_act = st_q.cmp_nxt;
                st_d.nxt_v   = 1'b0;
            end else begin
                st_d.act_v   = 1'b0;
            end
        end

        // control/status write
        if (csr_we_i) begin
            st_d.req_en = wdata_i[CSR_REQ_BIT];
            st_d.ie     = wdata_i[CSR_IE_BIT];
            st_d.mode   = wr_mode;
            if (wdata_i[CSR_FLAG_BIT] && !hit) begin
                st_d.flag = 1'b0;
            end
            if (wr_mode == MODE_OFF) begin
                st_d.act_v = 1'b0;
                st_d.nxt_v = 1'b0;
                st_d.pin   = 1'b0;
            end
        end

        // compare write: first value only while idle, later values queue
        if (cmp_we_i) begin
            if (!st_d.act_v) begin
                if (st_d.mode == MODE_OFF) begin
                    st_d.cmp_act = wdata_i;
                    st_d.act_v   = 1'b1;
                end
            end else begin
                st_d.cmp_nxt = wdata_i;
                st_d.nxt_v   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign csr_o   = {st_q.flag, st_q.ie, st_q.mode, 1'b0, st_q.req_en};
    assign cmp_o   = st_q.cmp_act;
    assign flag_o  = st_q.flag;
    assign irq_o   = st_q.flag & st_q.ie;
    assign pin_o   = st_q.pin;
    assign match_o = st_q.match;

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_PULSE && $past(st_q.mode) == MODE_PULSE) |-> (st_q.pin == st_q.match)); // R5
    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.match && st_q.mode == MODE_TOGGLE && $past(st_q.mode) == MODE_TOGGLE)
        |-> (st_q.pin != $past(st_q.pin))); // R6
    AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.match |-> st_q.flag); // R7
    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.match |-> $past(gen_en_i)); // R11
    AST_STEP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.match |-> $past(step_i)); // R4
    AST_FIRST_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_we_i && !csr_we_i && !st_q.act_v && st_q.mode != MODE_OFF) |=> !st_q.act_v); // R3
    AST_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we_i && wr_mode == MODE_OFF && !cmp_we_i) |=> (!st_q.act_v && !st_q.pin)); // R10
    AST_MATCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.match && !st_q.nxt_v && !$past(st_q.nxt_v) && !$past(cmp_we_i)) |-> !st_q.act_v); // R8

endmodule

// File: rtl/tcmp_unit.sv
module tcmp_unit
    import tcmp_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 31,
    parameter int AW  = 12,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CW-1:0]  cnt_i,
    input  logic           gen_en_i,
    input  logic           reg_wr_i,
    input  logic [AW-1:0]  reg_addr_i,
    input  logic [DW-1:0]  reg_wdata_i,
    output logic [DW-1:0]  reg_rdata_o,
    output logic [NCH-1:0] pin_o,
    output logic [NCH-1:0] match_o,
    output logic           irq_o
);

    typedef struct packed {
        logic [CW-1:0] cnt_prev;
    } top_st_t;

    top_st_t top_d, top_q;

    logic             step;
    logic             stat_hit;
    logic [NCH-1:0]   csr_hit, cmp_hit;
    logic [NCH-1:0]   flag_vec, irq_vec, ie_vec;
    logic [CSR_W-1:0] csr_rd [NCH];
    logic [CW-1:0]    cmp_rd [NCH];
    logic             wdata_unused;

    assign wdata_unused = ^reg_wdata_i[DW-1:CW];

    always_comb begin
        top_d          = top_q;
        top_d.cnt_prev = cnt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign step = (cnt_i != top_q.cnt_prev);

    tcmp_regdec #(
        .NCH (NCH),
        .AW  (AW)
    ) u_dec (
        .addr_i     (reg_addr_i),
        .stat_hit_o (stat_hit),
        .csr_hit_o  (csr_hit),
        .cmp_hit_o  (cmp_hit)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tcmp_chan #(
            .CW (CW)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt_i    (cnt_i),
            .step_i   (step),
            .gen_en_i (gen_en_i),
            .csr_we_i (reg_wr_i & csr_hit[i]),
            .cmp_we_i (reg_wr_i & cmp_hit[i]),
            .wdata_i  (reg_wdata_i[CW-1:0]),
            .csr_o    (csr_rd[i]),
            .cmp_o    (cmp_rd[i]),
            .flag_o   (flag_vec[i]),
            .irq_o    (irq_vec[i]),
            .pin_o    (pin_o[i]),
            .match_o  (match_o[i])
        );
        assign ie_vec[i] = csr_rd[i][CSR_IE_BIT];
    end

    assign irq_o = |irq_vec;

    always_comb begin
        reg_rdata_o = '0;
        if (stat_hit) begin
            reg_rdata_o = {{(DW-NCH){1'b0}}, flag_vec};
        end
        for (int i = 0; i < NCH; i++) begin
            if (csr_hit[i]) begin
                reg_rdata_o = {{(DW-CSR_W){1'b0}}, csr_rd[i]};
            end
            if (cmp_hit[i]) begin
                reg_rdata_o = {{(DW-CW){1'b0}}, cmp_rd[i]};
            end
        end
    end

    AST_IRQ_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (|(match_o & ie_vec)) |-> irq_o); // R9
    AST_MATCH_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (|match_o) |-> ((flag_vec & match_o) == match_o)); // R12

endmodule

// File: tb/tcmp_unit_test.sv
module tcmp_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_STAT = 12'h604;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [30:0] cnt = '0;
    logic        cnt_run = 1'b0;
    logic        gen_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  pin, match;
    logic        irq;

    int checks = 0;
    int failures = 0;
    logic [32:0] expq [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tcmp_unit uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_i       (cnt),
        .gen_en_i    (gen_en),
        .reg_wr_i    (reg_wr),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .pin_o       (pin),
        .match_o     (match),
        .irq_o       (irq)
    );

    function automatic logic [11:0] a_csr(int n);
        return 12'(12'h608 + 8 * n);
    endfunction

    function automatic logic [11:0] a_cmp(int n);
        return 12'(12'h60C + 8 * n);
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic push_exp(int ch, logic [30:0] v);
        expq.push_back({ch[1:0], v});
    endtask

    // waits for a match on channel ch, then checks the pin level
    task automatic wait_match(int ch, logic exp_pin, logic is_pulse, string tag);
        int n = 0;
        do begin
            @(posedge clk); #1;
            n++;
        end while (!match[ch] && n < 400);
        chk({tag, " match seen"}, 32'(match[ch]), 32'd1);
        chk({tag, " pin at event"}, 32'(pin[ch]), 32'(exp_pin));
        if (is_pulse) begin
            @(posedge clk); #1;
            chk({tag, " pin after one cycle"}, 32'(pin[ch]), 32'd0);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // counter source
    initial forever begin
        @(negedge clk); #2;
        if (cnt_run) cnt = cnt + 31'd1;
    end

    // scoreboard monitor: every match pulse must match the next expected item
    initial forever begin
        @(posedge clk); #1;
        if (rst_n) begin
            for (int c = 0; c < 4; c++) begin
                if (match[c]) begin
                    logic [32:0] e;
                    logic [32:0] g;
                    g = {c[1:0], cnt};
                    checks++;
                    if (expq.size() == 0) begin
                        failures++;
                        $display("FAIL R4 unexpected match got=%0h exp=none", g);
                    end else begin
                        e = expq.pop_front();
                        if (e !== g) begin
                            failures++;
                            $display("FAIL R8 event order got=%0h exp=%0h", g, e);
                        end
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog got=timeout exp=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(a_csr(0), v); chk("R1 csr0", v, 0);
        rd(a_cmp(0), v); chk("R1 cmp0", v, 0);
        rd(A_STAT, v);   chk("R1 status", v, 0);
        chk("R1 pins", 32'(pin), 0);
        chk("R1 match", 32'(match), 0);
        chk("R1 irq", 32'(irq), 0);

        // R2 field readback
        wr(a_csr(0), 32'h41);
        rd(a_csr(0), v); chk("R2 csr0 readback", v, 32'h41);
        wr(a_csr(0), 32'h0);

        // R3 first value refused while mode is not idle
        wr(a_csr(1), 32'h3C);
        wr(a_cmp(1), 32'd100);
        rd(a_cmp(1), v); chk("R3 cmp1 ignored", v, 0);
        wr(a_csr(1), 32'h0);

        // R5 / R8 pulse channel with queued and replaced value
        gen_en = 1'b1;
        cnt = 31'd1000;
        wr(a_cmp(0), 32'd1010);
        wr(a_csr(0), 32'h7C);
        wr(a_cmp(0), 32'd1020);
        wr(a_cmp(0), 32'd1025);
        rd(a_cmp(0), v); chk("R8 active value", v, 32'd1010);
        push_exp(0, 31'd1010);
        push_exp(0, 31'd1025);
        push_exp(0, 31'd1040);
        cnt_run = 1'b1;
        wait_match(0, 1'b1, 1'b1, "R5 first");
        chk("R9 irq with flag and enable", 32'(irq), 1);
        rd(A_STAT, v); chk("R2 status bit0", v, 1);
        rd(a_cmp(0), v); chk("R8 queued promoted", v, 32'd1025);
        wr(a_cmp(0), 32'd1040);
        wait_match(0, 1'b1, 1'b1, "R12 second");
        wait_match(0, 1'b1, 1'b1, "R8 third");
        cnt_run = 1'b0;

        // R7 flag clear semantics
        rd(a_csr(0), v); chk("R7 flag set", v, 32'hFC);
        wr(a_csr(0), 32'h7C);
        rd(a_csr(0), v); chk("R7 write zero keeps flag", v, 32'hFC);
        wr(a_csr(0), 32'hFC);
        rd(a_csr(0), v); chk("R7 write one clears", v, 32'h7C);
        chk("R9 irq low after clear", 32'(irq), 0);

        // R4 hold on value and value already passed
        cnt = 31'd2000;
        wr(a_cmp(2), 32'd2000);
        wr(a_csr(2), 32'h14);
        repeat (4) @(negedge clk);
        rd(A_STAT, v); chk("R4 held counter no match", v & 32'h4, 0);
        chk("R4 held pin", 32'(pin[2]), 0);
        cnt_run = 1'b1;
        repeat (10) @(negedge clk);
        cnt_run = 1'b0;
        rd(A_STAT, v); chk("R4 passed value waits", v & 32'h4, 0);

        // R10 disarm, R4 masking and wrap, R6 toggle
        wr(a_csr(2), 32'h0);
        wr(a_cmp(2), 32'h8000_0005);
        rd(a_cmp(2), v); chk("R4 value masked", v, 32'd5);
        wr(a_csr(2), 32'h14);
        wr(a_cmp(2), 32'd12);
        cnt = 31'h7FFF_FFFC;
        push_exp(2, 31'd5);
        push_exp(2, 31'd12);
        push_exp(2, 31'd20);
        cnt_run = 1'b1;
        wait_match(2, 1'b1, 1'b0, "R6 after wrap");
        chk("R9 no irq without enable", 32'(irq), 0);
        wr(a_cmp(2), 32'd20);
        wait_match(2, 1'b0, 1'b0, "R6 second");
        wait_match(2, 1'b1, 1'b0, "R6 third");
        wr(a_csr(2), 32'h0);
        chk("R10 pin low after disarm", 32'(pin[2]), 0);
        cnt_run = 1'b0;

        // R11 global enable low
        gen_en = 1'b0;
        cnt = 31'd3000;
        wr(a_cmp(3), 32'd3005);
        wr(a_csr(3), 32'h3C);
        cnt_run = 1'b1;
        repeat (12) @(negedge clk);
        cnt_run = 1'b0;
        rd(A_STAT, v); chk("R11 no flag when disabled", v & 32'h8, 0);
        chk("R11 pin low", 32'(pin[3]), 0);

        repeat (3) @(negedge clk);
        chk("R8 all expected events seen", 32'(expq.size()), 0);
        finish_run();
    end

endmodule